// File: doc/BRIEF.md
# BT.656 Raster Timing and Byte Formatter

This block produces line and field timing for one of five standard-definition rasters and interleaves 4:2:2 luma and chroma samples onto one 8-bit bus. The bus can carry embedded timing reference codes or plain multiplexed bytes with separate sync strobes. Every enabled clock is one byte slot, so each pixel takes two enabled clocks. Outputs are registered and change one enabled clock after the counter position they describe.

Each line begins with the end-of-active code. Horizontal blanking follows, and the start-of-active code closes it. The active samples fill the rest of the line. The horizontal sync strobe goes low a front-porch length after the line start and stays low for 60 pixels. The vertical counter runs two fields of different lengths. The standard in use (525 or 625 lines) follows the selected mode, and the line counts are elaboration parameters.

Mode select encoding: 0 = 601 NTSC, 1 = 601 PAL, 2 = square-pixel NTSC, 3 = square-pixel PAL, 4 = NTSC 4fsc. Values 5 to 7 behave as 0.

Top module: `vid_raster_fmt`

## Requirements
- R1: While reset is high, data_o is 0x00, hsync_l_o and vsync_l_o are 1, and hvalid_o, vvalid_o and odd_o are 0.
- R2: A line lasts 2 x total enabled clocks. The totals in pixels are 858 (mode 0), 864 (mode 1), 780 (mode 2), 944 (mode 3) and 910 (mode 4).
- R3: hvalid_o is high for exactly 2 x active byte slots per line, at the end of the line. The active widths are 720, 720, 640, 768 and 768 pixels, and the blanking widths are 138, 144, 140, 176 and 142 pixels, for modes 0 to 4 in that order.
- R4: hsync_l_o falls 2 x front-porch slots after the line start and stays low for 120 slots, never while hvalid_o is high. The front porches are 16, 14, 22, 34 and 16 pixels for modes 0 to 4.
- R5: In an active line, active slots carry Cb, Y, Cr, Y repeating, starting with Cb.
- R6: With plain_i = 0, the line's first four bytes are FF 00 00 XY (end code, H = 1). The last four blanking bytes are FF 00 00 XY (start code, H = 0). XY = {1, F, V, H, V^H, F^H, F^V, F^V^H}. F = 1 in the second field and V = 1 in vertical blanking lines.
- R7: Blanking bytes not used by codes, and every slot of a vertical-blanking line, carry 0x80 in chroma slots and 0x10 in luma slots. With pass_y_i = 1, luma slots in blanking carry y_i.
- R8: With plain_i = 1, no codes are inserted. Code slots carry the masked blanking values, and active data is unchanged.
- R9: The first field has F1 lines and the second has F2 lines. vvalid_o is low for the first VB1 or VB2 lines of each field. vsync_l_o is low for the first VS_LINES lines. odd_o is high during the first field and toggles at each field start.
- R10: While en_i is low, counters and all outputs hold.
- R11: mode_i is captured only while reset is high. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures mode_i |
| en_i | input | 1 | Byte-slot enable (twice the pixel rate) |
| mode_i | input | 3 | Raster mode select |
| plain_i | input | 1 | 1 = no embedded codes, 0 = embedded codes |
| pass_y_i | input | 1 | Let luma through during blanking |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Blue-difference sample |
| cr_i | input | 8 | Red-difference sample |
| data_o | output | 8 | Multiplexed output byte |
| hsync_l_o | output | 1 | Horizontal sync, active low |
| vsync_l_o | output | 1 | Vertical sync, active low |
| hvalid_o | output | 1 | Active pixel window |
| vvalid_o | output | 1 | Active line window |
| odd_o | output | 1 | First-field indicator |

## Verification
A wrong horizontal count shows on the next hsync_l_o edge or code byte, well within one line. A wrong phase of the low two counter bits swaps Cb and Cr or luma and chroma in the very next byte. A wrong vertical counter or field flag shows only at a line boundary: in the F and V bits of the next code word, in vvalid_o, or in odd_o. So field faults need up to a full field of lines to appear, and the vertical line counts are shortened in the bench to keep that wait small.

// File: rtl/vid_raster_pkg.sv
package vid_raster_pkg;
  localparam int PIXW   = 10;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    VM_NTSC601  = 3'd0,
    VM_PAL601   = 3'd1,
    VM_NTSC_SQ  = 3'd2,
    VM_PAL_SQ   = 3'd3,
    VM_NTSC4FSC = 3'd4
  } vmode_e;

  typedef struct packed {
    logic [PIXW-1:0] act;
    logic [PIXW-1:0] fp;
    logic [PIXW-1:0] hbl;
    logic            std625;
  } htiming_t;

  localparam logic [BYTE_W-1:0] MASK_C = 8'h80;
  localparam logic [BYTE_W-1:0] MASK_Y = 8'h10;

  function automatic htiming_t mode_timing(input logic [2:0] m);
    htiming_t t;
    case (vmode_e'(m))
      VM_PAL601:   t = '{act: 10'd720, fp: 10'd14, hbl: 10'd144, std625: 1'b1};
      VM_NTSC_SQ:  t = '{act: 10'd640, fp: 10'd22, hbl: 10'd140, std625: 1'b0};
      VM_PAL_SQ:   t = '{act: 10'd768, fp: 10'd34, hbl: 10'd176, std625: 1'b1};
      VM_NTSC4FSC: t = '{act: 10'd768, fp: 10'd16, hbl: 10'd142, std625: 1'b0};
      default:     t = '{act: 10'd720, fp: 10'd16, hbl: 10'd138, std625: 1'b0};
    endcase
    return t;
  endfunction

  function automatic logic [BYTE_W-1:0] xy_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/vid_htimer.sv
module vid_htimer
  import vid_raster_pkg::*;
#(
  parameter int HCW        = 11,
  parameter int SYNC_BYTES = 120
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  htiming_t   tim,
  output logic [1:0] pos,
  output logic       line_end,
  output logic       h_act,
  output logic       h_sync,
  output logic       code_eav,
  output logic       code_sav
);
  logic [HCW-1:0] hcnt;
  logic [HCW-1:0] blank2, total2, sync_lo, sync_hi;

  always_comb begin
    blank2   = HCW'({tim.hbl, 1'b0});
    total2   = HCW'({tim.act, 1'b0}) + blank2;
    sync_lo  = HCW'({tim.fp, 1'b0});
    sync_hi  = sync_lo + HCW'(SYNC_BYTES);
    line_end = (hcnt == total2 - HCW'(1));
    h_act    = (hcnt >= blank2);
    h_sync   = (hcnt >= sync_lo) && (hcnt < sync_hi);
    code_eav = (hcnt < HCW'(4));
    code_sav = (hcnt >= blank2 - HCW'(4)) && (hcnt < blank2);
    pos      = hcnt[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     hcnt <= '0;
    else if (en) hcnt <= line_end ? '0 : hcnt + HCW'(1);
  end
endmodule

// File: rtl/vid_vtimer.sv
module vid_vtimer #(
  parameter int F1_525   = 262,
  parameter int F2_525   = 263,
  parameter int VB1_525  = 20,
  parameter int VB2_525  = 21,
  parameter int F1_625   = 312,
  parameter int F2_625   = 313,
  parameter int VB1_625  = 23,
  parameter int VB2_625  = 24,
  parameter int VS_LINES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic line_end,
  input  logic std625,
  output logic fld,
  output logic v_blank,
  output logic v_sync
);
  localparam int MAX_A = (F1_525 > F2_525) ? F1_525 : F2_525;
  localparam int MAX_B = (F1_625 > F2_625) ? F1_625 : F2_625;
  localparam int MAXL  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int LCW   = $clog2(MAXL + 1);

  logic [LCW-1:0] lcnt, flen, vbl;

  always_comb begin
    if (std625) begin
      flen = fld ? LCW'(F2_625)  : LCW'(F1_625);
      vbl  = fld ? LCW'(VB2_625) : LCW'(VB1_625);
    end else begin
      flen = fld ? LCW'(F2_525)  : LCW'(F1_525);
      vbl  = fld ? LCW'(VB2_525) : LCW'(VB1_525);
    end
    v_blank = (lcnt < vbl);
    v_sync  = (lcnt < LCW'(VS_LINES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt <= '0;
      fld  <= 1'b0;
    end else if (en && line_end) begin
      if (lcnt == flen - LCW'(1)) begin
        lcnt <= '0;
        fld  <= ~fld;
      end else begin
        lcnt <= lcnt + LCW'(1);
      end
    end
  end
endmodule

// File: rtl/vid_byte_mux.sv
module vid_byte_mux
  import vid_raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              plain,
  input  logic              pass_y,
  input  logic [1:0]        pos,
  input  logic              h_act,
  input  logic              v_blank,
  input  logic              code_eav,
  input  logic              code_sav,
  input  logic              fld,
  input  logic [BYTE_W-1:0] y,
  input  logic [BYTE_W-1:0] cb,
  input  logic [BYTE_W-1:0] cr,
  output logic [BYTE_W-1:0] data_q
);
  logic [BYTE_W-1:0] nxt;

  always_comb begin
    if (!plain && (code_eav || code_sav)) begin
      case (pos)
        2'd0:    nxt = '1;
        2'd3:    nxt = xy_word(fld, v_blank, code_eav);
        default: nxt = '0;
      endcase
    end else if (h_act && !v_blank) begin
      case (pos)
        2'd0:    nxt = cb;
        2'd2:    nxt = cr;
        default: nxt = y;
      endcase
    end else if (pos[0]) begin
      nxt = pass_y ? y : MASK_Y;
    end else begin
      nxt = MASK_C;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     data_q <= '0;
    else if (en) data_q <= nxt;
  end

  // History of emitted bytes, used only to check the code word
  logic [3*BYTE_W-1:0] hist;
  logic                en_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      en_d <= 1'b0;
    end else begin
      en_d <= en;
      if (en) hist <= {hist[2*BYTE_W-1:0], data_q};
    end
  end

  // R6
  xy_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (en_d && !plain && hist == 24'hFF0000) |->
      (data_q[7] && data_q[3] == (data_q[5] ^ data_q[4]) &&
       data_q[2] == (data_q[6] ^ data_q[4]) && data_q[1] == (data_q[6] ^ data_q[5]) &&
       data_q[0] == (data_q[6] ^ data_q[5] ^ data_q[4])));
endmodule

// File: rtl/vid_raster_fmt.sv
module vid_raster_fmt
  import vid_raster_pkg::*;
#(
  parameter int HCW      = 11,
  parameter int SYNC_PIX = 60,
  parameter int F1_525   = 262,
  parameter int F2_525   = 263,
  parameter int VB1_525  = 20,
  parameter int VB2_525  = 21,
  parameter int F1_625   = 312,
  parameter int F2_625   = 313,
  parameter int VB1_625  = 23,
  parameter int VB2_625  = 24,
  parameter int VS_LINES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic       plain_i,
  input  logic       pass_y_i,
  input  logic [7:0] y_i,
  input  logic [7:0] cb_i,
  input  logic [7:0] cr_i,
  output logic [7:0] data_o,
  output logic       hsync_l_o,
  output logic       vsync_l_o,
  output logic       hvalid_o,
  output logic       vvalid_o,
  output logic       odd_o
);
  localparam int SYNC_BYTES = 2 * SYNC_PIX;
  localparam int RUNW       = $clog2(SYNC_BYTES + 2);

  logic [2:0] mode_q;
  htiming_t   tim;
  logic [1:0] pos;
  logic       line_end, h_act, h_sync, code_eav, code_sav;
  logic       fld, v_blank, v_sync;

  // Mode is taken only during reset
  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_i;
  end

  assign tim = mode_timing(mode_q);

  vid_htimer #(.HCW(HCW), .SYNC_BYTES(SYNC_BYTES)) u_htim (
    .clk(clk), .rst(rst), .en(en_i), .tim(tim), .pos(pos), .line_end(line_end),
    .h_act(h_act), .h_sync(h_sync), .code_eav(code_eav), .code_sav(code_sav)
  );

  vid_vtimer #(
    .F1_525(F1_525), .F2_525(F2_525), .VB1_525(VB1_525), .VB2_525(VB2_525),
    .F1_625(F1_625), .F2_625(F2_625), .VB1_625(VB1_625), .VB2_625(VB2_625),
    .VS_LINES(VS_LINES)
  ) u_vtim (
    .clk(clk), .rst(rst), .en(en_i), .line_end(line_end), .std625(tim.std625),
    .fld(fld), .v_blank(v_blank), .v_sync(v_sync)
  );

  vid_byte_mux u_mux (
    .clk(clk), .rst(rst), .en(en_i), .plain(plain_i), .pass_y(pass_y_i), .pos(pos),
    .h_act(h_act), .v_blank(v_blank), .code_eav(code_eav), .code_sav(code_sav),
    .fld(fld), .y(y_i), .cb(cb_i), .cr(cr_i), .data_q(data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_l_o <= 1'b1;
      vsync_l_o <= 1'b1;
      hvalid_o  <= 1'b0;
      vvalid_o  <= 1'b0;
      odd_o     <= 1'b0;
    end else if (en_i) begin
      hsync_l_o <= ~h_sync;
      vsync_l_o <= ~v_sync;
      hvalid_o  <= h_act;
      vvalid_o  <= ~v_blank;
      odd_o     <= ~fld;
    end
  end

  // Length of the current low sync run, for the width check
  logic [RUNW-1:0] sync_run;
  always_ff @(posedge clk) begin
    if (rst)          sync_run <= '0;
    else if (en_i)    sync_run <= hsync_l_o ? '0 : sync_run + RUNW'(1);
  end

  // R4
  hsync_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_l_o) |-> (sync_run == RUNW'(SYNC_BYTES)));

  // R4
  hsync_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !(hvalid_o && !hsync_l_o));

  // R9
  odd_at_vsync_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(odd_o) |-> !vsync_l_o);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(data_o) && $stable(hsync_l_o) && $stable(hvalid_o) &&
               $stable(vvalid_o) && $stable(odd_o)));
endmodule

// File: tb/vid_raster_fmt_tb.sv
module vid_raster_fmt_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic       plain_i = 1'b0;
  logic       pass_y_i = 1'b0;
  logic [7:0] y_i = 8'h52, cb_i = 8'h41, cr_i = 8'h63;
  logic [7:0] data_o;
  logic       hsync_l_o, vsync_l_o, hvalid_o, vvalid_o, odd_o;

  int total = 0;
  int fails = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  vid_raster_fmt #(
    .F1_525(6), .F2_525(7), .VB1_525(2), .VB2_525(3),
    .F1_625(7), .F2_625(8), .VB1_625(3), .VB2_625(4), .VS_LINES(1)
  ) u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .mode_i(mode_i), .plain_i(plain_i),
    .pass_y_i(pass_y_i), .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i), .data_o(data_o),
    .hsync_l_o(hsync_l_o), .vsync_l_o(vsync_l_o), .hvalid_o(hvalid_o),
    .vvalid_o(vvalid_o), .odd_o(odd_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      total++; fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic pl, input logic py);
    @(negedge clk);
    rst = 1'b1; en_i = 1'b1; mode_i = m; plain_i = pl; pass_y_i = py;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; en_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "data", data_o, 8'h00);
    chk("R1", "hsync_l", hsync_l_o, 1);
    chk("R1", "vsync_l", vsync_l_o, 1);
    chk("R1", "hvalid", hvalid_o, 0);
    chk("R1", "vvalid", vvalid_o, 0);
    chk("R1", "odd", odd_o, 0);
  endtask

  // Two lines of one mode: line length, active width, sync place and width, codes
  task automatic t_hline(input logic [2:0] m, input int a, input int fp, input int t);
    int fall1 = -1, fall2 = -1, run = 0, lowrun = -1, hv = 0;
    logic prevh = 1'b1;
    logic [31:0] eavw = '0, savw = '0;
    int hb = t - a;
    do_reset(m, 1'b0, 1'b0);
    for (int p = 0; p < 4 * t; p++) begin
      tick();
      if (p < 2 * t && hvalid_o) hv++;
      if (!hsync_l_o && prevh) begin
        if (fall1 < 0) fall1 = p; else if (fall2 < 0) fall2 = p;
      end
      if (!hsync_l_o) run++;
      else if (!prevh && lowrun < 0) lowrun = run;
      prevh = hsync_l_o;
      if (p < 4) eavw = {eavw[23:0], data_o};
      if (p >= 2 * hb - 4 && p < 2 * hb) savw = {savw[23:0], data_o};
    end
    chk("R2", "line length", fall2 - fall1, 2 * t);
    chk("R3", "active slots", hv, 2 * a);
    chk("R4", "sync start", fall1, 2 * fp);
    chk("R4", "sync width", lowrun, 120);
    chk("R6", "end code blank odd", eavw, 32'hFF0000B6);
    chk("R6", "start code blank odd", savw, 32'hFF0000AB);
  endtask

  task automatic t_active();
    int b = 4 * 858;
    logic [31:0] w0 = '0, wa = '0, we = '0, ws = '0, wb = '0;
    do_reset(3'd0, 1'b0, 1'b0);
    for (int p = 0; p < b + 280; p++) begin
      tick();
      if (p == 1) chk("R9", "vvalid in blank line", vvalid_o, 0);
      if (p >= 276 && p < 280) w0 = {w0[23:0], data_o};
      if (p >= b && p < b + 4) we = {we[23:0], data_o};
      if (p >= b + 4 && p < b + 8) wb = {wb[23:0], data_o};
      if (p == b + 1) chk("R9", "vvalid in active line", vvalid_o, 1);
      if (p >= b + 272 && p < b + 276) ws = {ws[23:0], data_o};
      if (p >= b + 276) wa = {wa[23:0], data_o};
    end
    chk("R7", "active slots of blank line", w0, 32'h80108010);
    chk("R6", "end code active odd", we, 32'hFF00009D);
    chk("R7", "horizontal blanking bytes", wb, 32'h80108010);
    chk("R6", "start code active odd", ws, 32'hFF000080);
    chk("R5", "sample order", wa, 32'h41526352);
  endtask

  task automatic t_passy();
    logic [31:0] we = '0, wb = '0, w0 = '0;
    do_reset(3'd0, 1'b0, 1'b1);
    for (int p = 0; p < 280; p++) begin
      tick();
      if (p < 4) we = {we[23:0], data_o};
      if (p >= 4 && p < 8) wb = {wb[23:0], data_o};
      if (p >= 276) w0 = {w0[23:0], data_o};
    end
    chk("R6", "codes kept with luma pass", we, 32'hFF0000B6);
    chk("R7", "luma pass in horizontal blank", wb, 32'h80528052);
    chk("R7", "luma pass in vertical blank", w0, 32'h80528052);
  endtask

  task automatic t_plain();
    int b = 4 * 858;
    logic [31:0] we = '0, ws = '0, wa = '0;
    logic hv = 1'b0;
    do_reset(3'd0, 1'b1, 1'b0);
    for (int p = 0; p < b + 280; p++) begin
      tick();
      if (p < 4) we = {we[23:0], data_o};
      if (p >= 272 && p < 276) ws = {ws[23:0], data_o};
      if (p >= b + 276) wa = {wa[23:0], data_o};
      if (p == b + 276) hv = hvalid_o;
    end
    chk("R8", "no end code", we, 32'h80108010);
    chk("R8", "no start code", ws, 32'h80108010);
    chk("R8", "active data plain", wa, 32'h41526352);
    chk("R8", "hvalid plain", hv, 1);
  endtask

  // 625-line raster with shortened fields: 7 lines (3 blank), then 8 (4 blank)
  task automatic t_field();
    logic [31:0] ws = '0, we = '0;
    do_reset(3'd1, 1'b0, 1'b0);
    for (int p = 0; p < 17 * 1728; p++) begin
      tick();
      if (p % 1728 == 1) begin
        int ln = p / 1728;
        int f  = (ln >= 7 && ln < 15) ? 1 : 0;
        int lc = (ln < 7) ? ln : ((ln < 15) ? ln - 7 : ln - 15);
        int vb = f ? 4 : 3;
        chk("R9", $sformatf("odd line %0d", ln), odd_o, f ? 0 : 1);
        chk("R9", $sformatf("vvalid line %0d", ln), vvalid_o, (lc >= vb) ? 1 : 0);
        chk("R9", $sformatf("vsync_l line %0d", ln), vsync_l_o, (lc >= 1) ? 1 : 0);
      end
      if (p >= 7 * 1728 && p < 7 * 1728 + 4) we = {we[23:0], data_o};
      if (p >= 12 * 1728 + 284 && p < 12 * 1728 + 288) ws = {ws[23:0], data_o};
    end
    chk("R6", "end code blank even", we, 32'hFF0000F1);
    chk("R6", "start code active even", ws, 32'hFF0000C7);
  endtask

  task automatic t_freeze();
    logic [7:0] d0;
    logic h0, v0;
    do_reset(3'd0, 1'b0, 1'b0);
    repeat (300) tick();
    d0 = data_o; h0 = hvalid_o; v0 = hsync_l_o;
    en_i = 1'b0;
    repeat (19) tick();
    chk("R10", "data held", data_o, d0);
    chk("R10", "hvalid held", hvalid_o, h0);
    chk("R10", "hsync_l held", hsync_l_o, v0);
    en_i = 1'b1;
    tick();
    chk("R10", "position resumes", data_o, 8'h80);
  endtask

  task automatic t_mode();
    int fall1 = -1, fall2 = -1;
    logic prevh = 1'b1;
    do_reset(3'd0, 1'b0, 1'b0);
    mode_i = 3'd3;
    for (int p = 0; p < 1716 + 40; p++) begin
      tick();
      if (!hsync_l_o && prevh) begin
        if (fall1 < 0) fall1 = p; else if (fall2 < 0) fall2 = p;
      end
      prevh = hsync_l_o;
    end
    chk("R11", "sync start after mode change", fall1, 32);
    chk("R11", "line length after mode change", fall2 - fall1, 1716);
  endtask

  initial begin
    t_reset();
    t_hline(3'd0, 720, 16, 858);
    t_hline(3'd1, 720, 14, 864);
    t_hline(3'd2, 640, 22, 780);
    t_hline(3'd3, 768, 34, 944);
    t_hline(3'd4, 768, 16, 910);
    t_active();
    t_passy();
    t_plain();
    t_field();
    t_freeze();
    t_mode();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule